// File: doc/BRIEF.md
# CTS-Paced Command Transmit Sequencer

This block feeds command bytes, one at a time, to a slow peripheral that uses its clear-to-send line to say when it is busy. It takes a byte over a valid/ready handshake and starts an external UART transmitter with it. It then waits for the peripheral to drop CTS and later raise it again before it takes another byte. At most one command is in flight at any time, and bytes are never queued ahead of the device.

The transmitter finishing the byte only means the byte left the wire, not that the device acted on it. For this reason the return to the idle phase depends only on the full CTS drop-and-raise cycle. A programmable watchdog limit covers a device that never drops CTS. A two-bit phase output shows where the sequence stands.

Top module: `cts_cmd_pacer`

## Requirements
- R1: `phase` uses the codes 0 = Ready, 1 = CommandSent and 2 = DeviceBusy, and never shows 3. The only transitions are 0→1, 1→2 and 2→0, plus 1→0 on timeout.
- R2: `cmd_ready` is high exactly when `phase` is 0 and `tx_busy` is low.
- R3: When `cmd_valid` and `cmd_ready` are both high at a rising edge, the byte is taken. In the next cycle `tx_start` is high for exactly one cycle, `tx_data` equals the byte and `phase` is 1.
- R4: CTS passes through a two-flop synchronizer. When `phase` is 1 and the first rising edge samples `cts` low, `phase` becomes 2 at the third rising edge, counting that sampling edge as the first.
- R5: When `phase` is 2, a CTS rise moves `phase` to 0 with the same three-edge latency. `tx_busy` has no effect on leaving phase 2.
- R6: CTS edges seen while `phase` is 0, and CTS rises seen while `phase` is 1, do not change `phase`.
- R7: If `phase` has been 1 for `timeout_limit`+1 cycles and no CTS fall has been detected, `phase` returns to 0. `timeout_err` is high for exactly that first Ready cycle. A CTS fall detected in the last cycle takes priority over the timeout.
- R8: At all other times `timeout_err` is low.
- R9: While `rst` is high at a rising edge, the block enters phase 0 with `tx_start` and `timeout_err` low and `tx_data` at zero.
- R10: `tx_data` changes only in the cycle after a byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command byte is offered |
| cmd_data | input | DATA_W | The command byte |
| cmd_ready | output | 1 | The sequencer will take a byte this cycle |
| tx_start | output | 1 | One-cycle start pulse to the transmitter |
| tx_data | output | DATA_W | Byte handed to the transmitter |
| tx_busy | input | 1 | The transmitter is shifting a byte |
| cts | input | 1 | Clear-to-send from the device, high = clear, asynchronous |
| timeout_limit | input | TMO_W | Extra cycles allowed in CommandSent before giving up |
| timeout_err | output | 1 | One-cycle pulse when CommandSent times out |
| phase | output | 2 | Current phase code |

## Verification
A wrong internal phase is visible at the ports on the very next compare, because `phase` is a registered copy of the state and `cmd_ready` is derived from it. An off-by-one in the synchronizer depth, or an edge detector of the wrong polarity, shifts the CommandSent→DeviceBusy or DeviceBusy→Ready move by a cycle. It can also swallow that move entirely, which shows up in `phase` three edges after CTS changes. A miscounted watchdog moves the `timeout_err` pulse and the return to Ready earlier or later than `timeout_limit`+1 cycles. A bench model running alongside the design catches this in the first cycle where the two disagree.

// File: rtl/cts_pacer_pkg.sv
package cts_pacer_pkg;

  typedef enum logic [1:0] {
    PH_READY = 2'd0,
    PH_SENT  = 2'd1,
    PH_BUSY  = 2'd2
  } pacer_phase_e;

  // Next phase of the pacing sequence. The timeout only applies in PH_SENT,
  // and a detected fall outranks it.
  function automatic pacer_phase_e next_phase(
    input pacer_phase_e cur,
    input logic         take,
    input logic         fall,
    input logic         rise,
    input logic         expired
  );
    pacer_phase_e nxt;
    nxt = cur;
    unique case (cur)
      PH_READY: if (take)    nxt = PH_SENT;
      PH_SENT:  if (fall)    nxt = PH_BUSY;
                else if (expired) nxt = PH_READY;
      PH_BUSY:  if (rise)    nxt = PH_READY;
      default:               nxt = PH_READY;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/cts_edge_sync.sv
module cts_edge_sync #(
  parameter int    STAGES   = 2,
  parameter logic  IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic fell,
  output logic rose
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;
  logic         last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE_LVL}};
      last  <= IDLE_LVL;
    end else begin
      chain <= {chain[TOP-1:0], async_in};
      last  <= chain[TOP];
    end
  end

  assign level = chain[TOP];
  assign fell  = last & ~chain[TOP];
  assign rose  = ~last & chain[TOP];
endmodule

// File: rtl/pacer_timeout.sv
module pacer_timeout #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  function automatic logic reached(input logic [TMO_W-1:0] c,
                                   input logic [TMO_W-1:0] l);
    return c >= l;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign expired = run && reached(cnt, limit);
endmodule

// File: rtl/pacer_fsm.sv
module pacer_fsm
  import cts_pacer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              tx_busy,
  input  logic              cts_fall,
  input  logic              cts_rise,
  input  logic              tmo_expired,
  output logic              cmd_ready,
  output logic              accept,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_data,
  output logic              timeout_err,
  output pacer_phase_e      phase
);
  pacer_phase_e nxt;
  logic         give_up;

  assign cmd_ready = (phase == PH_READY) && !tx_busy;
  assign accept    = cmd_valid && cmd_ready;
  assign give_up   = (phase == PH_SENT) && !cts_fall && tmo_expired;
  assign nxt       = next_phase(phase, accept, cts_fall, cts_rise, tmo_expired);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_READY;
      tx_start    <= 1'b0;
      tx_data     <= '0;
      timeout_err <= 1'b0;
    end else begin
      phase       <= nxt;
      tx_start    <= accept;
      timeout_err <= give_up;
      if (accept) tx_data <= cmd_data;
    end
  end
endmodule

// File: rtl/cts_cmd_pacer.sv
module cts_cmd_pacer
  import cts_pacer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              cmd_ready,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_busy,
  input  logic              cts,
  input  logic [TMO_W-1:0]  timeout_limit,
  output logic              timeout_err,
  output logic [1:0]        phase
);
  // Internal events, named so the checker can reach them
  logic         cts_level;
  logic         cts_fall;
  logic         cts_rise;
  logic         tmo_expired;
  logic         accept;
  logic         in_sent;
  pacer_phase_e cur_phase;

  cts_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (cts),
    .level    (cts_level),
    .fell     (cts_fall),
    .rose     (cts_rise)
  );

  assign in_sent = (cur_phase == PH_SENT);

  pacer_timeout #(.TMO_W(TMO_W)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .run     (in_sent),
    .limit   (timeout_limit),
    .expired (tmo_expired)
  );

  pacer_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_data    (cmd_data),
    .tx_busy     (tx_busy),
    .cts_fall    (cts_fall),
    .cts_rise    (cts_rise),
    .tmo_expired (tmo_expired),
    .cmd_ready   (cmd_ready),
    .accept      (accept),
    .tx_start    (tx_start),
    .tx_data     (tx_data),
    .timeout_err (timeout_err),
    .phase       (cur_phase)
  );

  assign phase = cur_phase;
endmodule

// File: rtl/cts_pacer_chk.sv
module cts_pacer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              tx_start,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_busy,
  input logic              timeout_err,
  input logic [1:0]        phase,
  input logic              cts_fall,
  input logic              cts_rise,
  input logic              cts_level
);
  a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);

  a_r1_busy_never_to_sent: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd2 |=> phase != 2'd1);

  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (phase == 2'd0 && !tx_busy));

  a_r3_take_starts_tx: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (tx_start && phase == 2'd1));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  a_r4_fall_to_busy: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd1 && cts_fall) |=> phase == 2'd2);

  a_r5_rise_to_ready: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && cts_rise) |=> phase == 2'd0);

  a_r5_busy_holds_while_low: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && !cts_level) |=> phase == 2'd2);

  a_r7_err_after_sent: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (phase == 2'd0 && $past(phase) == 2'd1));

  a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> !timeout_err);

  a_r10_data_hold: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_ready) |=> $stable(tx_data));
endmodule

bind cts_cmd_pacer cts_pacer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .tx_start    (tx_start),
  .tx_data     (tx_data),
  .tx_busy     (tx_busy),
  .timeout_err (timeout_err),
  .phase       (phase),
  .cts_fall    (cts_fall),
  .cts_rise    (cts_rise),
  .cts_level   (cts_level)
);

// File: tb/sim_cts_cmd_pacer.sv
`timescale 1ns/1ps
module sim_cts_cmd_pacer;
  localparam int DW = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          cmd_valid;
  logic [DW-1:0] cmd_data;
  logic          cmd_ready;
  logic          tx_start;
  logic [DW-1:0] tx_data;
  logic          tx_busy;
  logic          cts;
  logic [TW-1:0] timeout_limit;
  logic          timeout_err;
  logic [1:0]    phase;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;

  always #4 clk = ~clk;   // 125 MHz

  cts_cmd_pacer #(.DATA_W(DW), .TMO_W(TW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .tx_start(tx_start), .tx_data(tx_data),
    .tx_busy(tx_busy), .cts(cts), .timeout_limit(timeout_limit),
    .timeout_err(timeout_err), .phase(phase)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Behavioural reference: CTS history as a delay list, phase as an integer
  bit  hist[$];           // [0]=newest sampled, [1]=synced, [2]=synced one edge earlier
  int  m_phase, m_wait;
  bit  m_start, m_err;
  int  m_data;
  bit  m_live = 0;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{1'b1, 1'b1, 1'b1};
      m_phase = 0; m_wait = 0; m_start = 0; m_err = 0; m_data = 0;
      m_live = 1;
    end else if (m_live) begin
      bit went_low, went_high;
      went_low  = hist[2] && !hist[1];
      went_high = !hist[2] && hist[1];
      m_start = 0; m_err = 0;
      if (m_phase == 0) begin
        if (cmd_valid && !tx_busy) begin
          m_phase = 1; m_start = 1; m_data = cmd_data; m_wait = 0;
        end
      end else if (m_phase == 1) begin
        if (went_low) m_phase = 2;
        else if (m_wait >= timeout_limit) begin m_phase = 0; m_err = 1; end
        else m_wait++;
      end else begin
        if (went_high) m_phase = 0;
      end
      hist.push_front(cts);
      hist.pop_back();
    end
  end

  // Per-cycle comparison, clear of the edge and before inputs move at negedge
  always @(posedge clk) begin
    #2;
    if (m_live && !done) begin
      check("R1 phase", phase, m_phase);
      check("R2 cmd_ready", cmd_ready, (m_phase == 0) && !tx_busy);
      check("R3 tx_start", tx_start, m_start);
      check("R10 tx_data", tx_data, m_data);
      check("R7 R8 timeout_err", timeout_err, m_err);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1; cmd_valid = 0; cmd_data = 0; tx_busy = 0; cts = 1; timeout_limit = 20;
    cyc(3);
    check("R9 reset phase", phase, 0);
    check("R9 reset tx_start", tx_start, 0);
    check("R9 reset err", timeout_err, 0);
    check("R9 reset tx_data", tx_data, 0);
    rst = 0;
    cyc(2);

    // Normal cycle with direct latency checks
    cmd_valid = 1; cmd_data = 8'hA5;
    cyc(1);
    cmd_valid = 0;
    check("R3 start", tx_start, 1);
    check("R3 data", tx_data, 8'hA5);
    check("R3 phase", phase, 1);
    cts = 1; cyc(1);
    check("R3 one pulse", tx_start, 0);
    cts = 0;                   // first sampling edge is the next one
    cyc(2);
    check("R4 still sent", phase, 1);
    cyc(1);
    check("R4 busy", phase, 2);
    tx_busy = 1; cyc(1); tx_busy = 0; cyc(1);
    check("R5 tx idle no effect", phase, 2);
    cmd_valid = 1; cmd_data = 8'h3C;
    cyc(1);
    check("R5 no take while busy", tx_start, 0);
    cmd_valid = 0;
    cts = 1; cyc(2);
    check("R5 still busy", phase, 2);
    cyc(1);
    check("R5 ready", phase, 0);

    // CTS edges in Ready are ignored
    cts = 0; cyc(4); cts = 1; cyc(4);
    check("R6 ready ignores cts", phase, 0);

    // tx_busy holds off the handshake
    tx_busy = 1; cmd_valid = 1; cmd_data = 8'h11;
    cyc(1);
    check("R2 held by tx_busy", phase, 0);
    tx_busy = 0; cyc(1); cmd_valid = 0;
    check("R3 taken", tx_data, 8'h11);

    // Rise while in CommandSent is ignored; short drop still advances
    cts = 0; cyc(1); cts = 1; cyc(2);
    check("R4 glitch fall seen", phase, 2);
    cyc(2);
    check("R5 back to ready", phase, 0);

    // Timeout with limit 3
    timeout_limit = 3;
    cmd_valid = 1; cmd_data = 8'h7E; cyc(1); cmd_valid = 0;
    cyc(3);
    check("R7 sent before limit", phase, 1);
    check("R8 no err yet", timeout_err, 0);
    cyc(1);
    check("R7 ready after limit", phase, 0);
    check("R7 err pulse", timeout_err, 1);
    cyc(1);
    check("R8 err cleared", timeout_err, 0);

    // Timeout with limit 0
    timeout_limit = 0;
    cmd_valid = 1; cmd_data = 8'h01; cyc(1); cmd_valid = 0;
    check("R7 limit0 sent", phase, 1);
    cyc(1);
    check("R7 limit0 err", timeout_err, 1);

    // Random traffic
    timeout_limit = 12;
    for (int i = 0; i < 4000; i++) begin
      cmd_valid = ($urandom % 2) == 1;
      cmd_data  = DW'($urandom);
      tx_busy   = ($urandom % 4) == 0;
      if (($urandom % 6) == 0) cts = ~cts;
      cyc(1);
    end
    cmd_valid = 0;
    cyc(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule